// File: doc/BRIEF.md
# DMA Channel Status and Condition Unit

This block keeps the 16-bit control and status word of one channel of a descriptor-driven DMA engine. It also decides, for the command that is executing, whether to raise an interrupt, whether to branch and whether to wait. The upper byte holds the run-state flags. The lower byte is device status, and both software and the hardware datapath can change it. Every write to the word is qualified by a mask, so a writer changes only the bits it selects.

Three selectors, one each for interrupt, branch and wait, hold an 8-bit mask and an 8-bit value. A selector is satisfied when the device-status byte ANDed with its mask equals its value. Each field of the current command carries a 2-bit code that picks one of four outcomes: never, on the selector being satisfied, on it not being satisfied, or always.

When the engine reports that a command has completed, the block returns a 32-bit word to be stored back into the descriptor. The word holds the channel status as it stood at completion and the residual byte count. It also records a taken branch in the status word.

Top module: `dma_chan_cond`

## Requirements
- R1: After reset the status word is 0x0000, all selector masks and values are zero, and take_int, take_br, must_wait and wb_valid are low.
- R2: A software write changes exactly the status bits whose mask bit is 1, and each of those bits takes the matching value bit. Bit 10 (active) and bit 9 (reserved, always 0) ignore software writes. Bit 8 (branch taken) can be cleared by software.
- R3: A hardware device-status update changes only the bits of the low byte selected by its 8-bit mask, for example mask 0x03 with value 0x00 clears bits 1:0. If software writes the same bits in the same cycle, the software value wins.
- R4: Selector index 0 is interrupt, 1 is branch and 2 is wait. A selector is satisfied when (status[7:0] & mask) == value. Code 0 gives 0, code 1 gives the satisfied result, code 2 gives its inverse, and code 3 gives 1.
- R5: take_int, take_br and must_wait can be high only while run (bit 15) is 1 and dead (bit 11) is 0. take_int and take_br also need cmd_valid. When dead is 1, all three are low.
- R6: When run goes from 0 to 1, active (bit 10) is set. When run is 0, active and dead are 0 and any pending wait is dropped.
- R7: A wait decision that is true while a command is valid is latched. must_wait then stays high even if the condition stops holding, until wake (bit 12) is set. The cycle after wake is set, the wait is evaluated again from the current status. Wake clears itself after one cycle.
- R8: cmd_done is accepted while run is 1 and dead is 0. One cycle after an accepted cmd_done, wb_valid is high for one cycle with wb_word = {status before the completion, residual}. The residual is req_bytes minus act_bytes, or zero for opcode 6 (nop) and opcode 7 (stop).
- R9: An accepted completion whose take_br is high sets bit 8. A completion with opcode 7 clears active and leaves run unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Software write strobe for the status word |
| sw_mask | input | 16 | Bits to change on a software write |
| sw_val | input | 16 | New values for the selected bits |
| hw_dev_wr | input | 1 | Hardware device-status update strobe |
| hw_dev_mask | input | 8 | Device-status bits to change |
| hw_dev_val | input | 8 | New device-status values |
| sel_wr | input | 1 | Selector write strobe |
| sel_idx | input | 2 | Selector index: 0 interrupt, 1 branch, 2 wait |
| sel_mask | input | 8 | Selector mask |
| sel_val | input | 8 | Selector compare value |
| cmd_valid | input | 1 | A command is currently executing |
| cmd_op | input | 3 | Opcode of the current command |
| cmd_int | input | 2 | Interrupt condition code |
| cmd_br | input | 2 | Branch condition code |
| cmd_wait | input | 2 | Wait condition code |
| cmd_done | input | 1 | The current command completes this cycle |
| req_bytes | input | 16 | Requested byte count |
| act_bytes | input | 16 | Byte count actually moved |
| chan_status | output | 16 | Channel status word |
| take_int | output | 1 | Raise an interrupt for this command |
| take_br | output | 1 | Branch for this command |
| must_wait | output | 1 | Hold the command in a wait |
| wb_valid | output | 1 | Writeback word is valid |
| wb_word | output | 32 | {status, residual} to store into the descriptor |

## Verification
Most internal state reaches chan_status at the next clock edge, so a wrong status bit is seen one cycle after the write that caused it. The exceptions are the selectors and the latched wait. A corrupt selector shows only when a command with a conditional code is presented, through a wrong take_int or take_br in that same cycle. A stale wait latch shows when must_wait stays high after the wake re-evaluation, or comes back after run has been cycled. Writeback errors show in wb_word one cycle after completion, in both the status half and the residual half.

// File: rtl/dma_chan_cond.sv
module dma_chan_cond (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr,
  input  logic [15:0] sw_mask,
  input  logic [15:0] sw_val,
  input  logic        hw_dev_wr,
  input  logic [7:0]  hw_dev_mask,
  input  logic [7:0]  hw_dev_val,
  input  logic        sel_wr,
  input  logic [1:0]  sel_idx,
  input  logic [7:0]  sel_mask,
  input  logic [7:0]  sel_val,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [1:0]  cmd_int,
  input  logic [1:0]  cmd_br,
  input  logic [1:0]  cmd_wait,
  input  logic        cmd_done,
  input  logic [15:0] req_bytes,
  input  logic [15:0] act_bytes,
  output logic [15:0] chan_status,
  output logic        take_int,
  output logic        take_br,
  output logic        must_wait,
  output logic        wb_valid,
  output logic [31:0] wb_word
);
  localparam int RUN = 15, WAKE = 12, DEAD = 11, ACT = 10, BRT = 8;
  localparam logic [15:0] SW_OK = 16'hF9FF;
  localparam logic [2:0] OP_NOP = 3'd6, OP_STOP = 3'd7;

  logic [15:0] cs, nx;
  logic [7:0]  sm [3];
  logic [7:0]  sv [3];
  logic [2:0]  hit;
  logic        wait_q, live, done_ok, wait_now;

  function automatic logic decide(input logic [1:0] code, input logic h);
    case (code)
      2'd0:    decide = 1'b0;
      2'd1:    decide = h;
      2'd2:    decide = ~h;
      default: decide = 1'b1;
    endcase
  endfunction

  for (genvar k = 0; k < 3; k++) begin : g_hit
    assign hit[k] = ((cs[7:0] & sm[k]) == sv[k]);
  end

  assign live      = cs[RUN] & ~cs[DEAD];
  assign take_int  = live & cmd_valid & decide(cmd_int, hit[0]);
  assign take_br   = live & cmd_valid & decide(cmd_br, hit[1]);
  assign wait_now  = cmd_valid & decide(cmd_wait, hit[2]);
  assign must_wait = live & (wait_q | wait_now);
  assign done_ok   = live & cmd_done;
  assign chan_status = cs;

  always_comb begin
    nx = cs;
    nx[WAKE] = 1'b0;
    if (hw_dev_wr) nx[7:0] = (nx[7:0] & ~hw_dev_mask) | (hw_dev_val & hw_dev_mask);
    if (sw_wr) nx = (nx & ~(sw_mask & SW_OK)) | (sw_val & sw_mask & SW_OK);
    if (done_ok && take_br) nx[BRT] = 1'b1;
    if (done_ok && cmd_op == OP_STOP) nx[ACT] = 1'b0;
    if (!cs[RUN] && nx[RUN]) nx[ACT] = 1'b1;
    if (!nx[RUN]) begin
      nx[ACT]  = 1'b0;
      nx[DEAD] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs       <= '0;
      wait_q   <= 1'b0;
      wb_valid <= 1'b0;
      wb_word  <= '0;
      for (int k = 0; k < 3; k++) begin
        sm[k] <= '0;
        sv[k] <= '0;
      end
    end else begin
      cs <= nx;
      if (sel_wr && sel_idx != 2'd3) begin
        sm[sel_idx] <= sel_mask;
        sv[sel_idx] <= sel_val;
      end
      if (!nx[RUN])                 wait_q <= 1'b0;
      else if (cs[WAKE] && wait_q)  wait_q <= live & wait_now;
      else if (live && wait_now)    wait_q <= 1'b1;
      wb_valid <= done_ok;
      if (done_ok)
        wb_word <= {cs, (cmd_op == OP_NOP || cmd_op == OP_STOP) ? 16'd0 : req_bytes - act_bytes};
    end
  end
endmodule

module dma_chan_cond_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_wr,
  input logic [15:0] sw_mask,
  input logic [15:0] sw_val,
  input logic        hw_dev_wr,
  input logic [7:0]  hw_dev_mask,
  input logic [7:0]  hw_dev_val,
  input logic        cmd_done,
  input logic [15:0] chan_status,
  input logic        take_int,
  input logic        take_br,
  input logic        must_wait,
  input logic        wb_valid
);
  // R5
  dead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_status[11] |-> !take_int && !take_br && !must_wait);
  // R6
  idle_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_status[15] |-> !chan_status[10] && !chan_status[11]);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_status[9]);
  // R7
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_status[12] && !(sw_wr && sw_mask[12] && sw_val[12]) |=> !chan_status[12]);
  // R8
  wb_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(cmd_done));
  // R3
  hw_dev_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_dev_wr && !sw_wr |=> chan_status[7:0] ==
      $past((chan_status[7:0] & ~hw_dev_mask) | (hw_dev_val & hw_dev_mask)));
endmodule

bind dma_chan_cond dma_chan_cond_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_mask(sw_mask), .sw_val(sw_val),
  .hw_dev_wr(hw_dev_wr), .hw_dev_mask(hw_dev_mask), .hw_dev_val(hw_dev_val),
  .cmd_done(cmd_done), .chan_status(chan_status), .take_int(take_int),
  .take_br(take_br), .must_wait(must_wait), .wb_valid(wb_valid)
);

// File: tb/dma_chan_cond_tb.sv
module dma_chan_cond_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_wr = 0, hw_dev_wr = 0, sel_wr = 0, cmd_valid = 0, cmd_done = 0;
  logic [15:0] sw_mask = 0, sw_val = 0, req_bytes = 0, act_bytes = 0;
  logic [7:0]  hw_dev_mask = 0, hw_dev_val = 0, sel_mask = 0, sel_val = 0;
  logic [1:0]  sel_idx = 0, cmd_int = 0, cmd_br = 0, cmd_wait = 0;
  logic [2:0]  cmd_op = 0;
  logic [15:0] chan_status;
  logic take_int, take_br, must_wait, wb_valid;
  logic [31:0] wb_word;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dma_chan_cond dut_i (.*);

  // {dev, mask, value, code, expected}
  localparam logic [26:0] VEC [8] = '{
    {8'h5A, 8'h0F, 8'h0A, 2'd1, 1'b1},
    {8'h5A, 8'h0F, 8'h0A, 2'd2, 1'b0},
    {8'h5A, 8'hF0, 8'h40, 2'd1, 1'b0},
    {8'h5A, 8'hF0, 8'h40, 2'd2, 1'b1},
    {8'h5A, 8'hF0, 8'h40, 2'd0, 1'b0},
    {8'h5A, 8'hF0, 8'h40, 2'd3, 1'b1},
    {8'hFF, 8'h00, 8'h00, 2'd1, 1'b1},
    {8'h00, 8'h81, 8'h81, 2'd2, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [15:0] m, input logic [15:0] v);
    sw_wr = 1; sw_mask = m; sw_val = v;
    @(negedge clk);
    sw_wr = 0;
  endtask

  task automatic sel_write(input logic [1:0] i, input logic [7:0] m, input logic [7:0] v);
    sel_wr = 1; sel_idx = i; sel_mask = m; sel_val = v;
    @(negedge clk);
    sel_wr = 0;
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    cmd_valid = 1; cmd_int = 2'd3; cmd_br = 2'd3; cmd_wait = 2'd3;
    #1;
    chk("R1 status", chan_status, 16'h0000);
    chk("R1 outputs", {take_int, take_br, must_wait, wb_valid}, 4'b0000);
    cmd_valid = 0;
    rst_n = 1;
    @(negedge clk);

    sw_write(16'h0600, 16'h0600);
    chk("R2 active/reserved ignore sw", chan_status, 16'h0000);
    sw_write(16'h00FF, 16'h00A5);
    chk("R2 low byte write", chan_status, 16'h00A5);
    sw_write(16'h000F, 16'h0000);
    chk("R2 masked clear", chan_status, 16'h00A0);

    sw_write(16'h8000, 16'h8000);
    chk("R6 run sets active", chan_status, 16'h84A0);

    hw_dev_wr = 1; hw_dev_mask = 8'h03; hw_dev_val = 8'h03;
    @(negedge clk);
    chk("R3 hw update", chan_status, 16'h84A3);
    hw_dev_mask = 8'h0F; hw_dev_val = 8'h0F;
    sw_write(16'h0003, 16'h0000);
    hw_dev_wr = 0;
    chk("R3 sw wins overlap", chan_status, 16'h84AC);

    for (int i = 0; i < 8; i++) begin
      sw_write(16'h00FF, {8'h00, VEC[i][26:19]});
      sel_write(2'd0, VEC[i][18:11], VEC[i][10:3]);
      sel_write(2'd1, VEC[i][18:11], VEC[i][10:3]);
      cmd_valid = 1; cmd_int = VEC[i][2:1]; cmd_br = VEC[i][2:1];
      #1;
      chk("R4 interrupt decision", take_int, VEC[i][0]);
      chk("R4 branch decision", take_br, VEC[i][0]);
      @(negedge clk);
      cmd_valid = 0;
    end

    cmd_int = 2'd3; cmd_br = 2'd3; cmd_wait = 2'd3;
    #1;
    chk("R5 no command no decision", {take_int, take_br}, 2'b00);
    sw_write(16'h0800, 16'h0800);
    cmd_valid = 1;
    #1;
    chk("R5 dead holds outputs low", {take_int, take_br, must_wait}, 3'b000);
    cmd_valid = 0;
    sw_write(16'h8000, 16'h0000);
    chk("R6 run clear drops active and dead", chan_status[15:8], 8'h00);

    sw_write(16'h8000, 16'h8000);
    sel_write(2'd2, 8'h01, 8'h01);
    sw_write(16'h00FF, 16'h0001);
    cmd_valid = 1; cmd_wait = 2'd1;
    #1;
    chk("R7 wait decision", must_wait, 1'b1);
    @(negedge clk);
    sw_write(16'h00FF, 16'h0000);
    chk("R7 wait latched", must_wait, 1'b1);
    sw_write(16'h1000, 16'h1000);
    chk("R7 wake bit set", chan_status[12], 1'b1);
    chk("R7 still waiting before re-evaluation", must_wait, 1'b1);
    @(negedge clk);
    chk("R7 wake re-evaluates", must_wait, 1'b0);
    chk("R7 wake self-clears", chan_status[12], 1'b0);
    sw_write(16'h00FF, 16'h0001);
    @(negedge clk);
    sw_write(16'h80FF, 16'h0000);
    sw_write(16'h8000, 16'h8000);
    chk("R6 run clear drops pending wait", must_wait, 1'b0);
    cmd_valid = 0; cmd_wait = 2'd0;
    @(negedge clk);

    chk("R8 status before completion", chan_status, 16'h8400);
    cmd_valid = 1; cmd_op = 3'd1; cmd_br = 2'd3; cmd_int = 2'd0;
    cmd_done = 1; req_bytes = 16'd100; act_bytes = 16'd60;
    @(negedge clk);
    cmd_done = 0;
    chk("R8 writeback valid", wb_valid, 1'b1);
    chk("R8 writeback word", wb_word, {16'h8400, 16'd40});
    chk("R9 branch bit set", chan_status, 16'h8500);
    @(negedge clk);
    chk("R8 writeback one cycle", wb_valid, 1'b0);

    cmd_op = 3'd7; cmd_br = 2'd0; cmd_done = 1; req_bytes = 16'd50; act_bytes = 16'd10;
    @(negedge clk);
    cmd_done = 0;
    chk("R8 stop residual zero", wb_word, {16'h8500, 16'd0});
    chk("R9 stop clears active keeps run", chan_status, 16'h8100);

    cmd_op = 3'd6; cmd_done = 1;
    @(negedge clk);
    cmd_done = 0; cmd_valid = 0;
    chk("R8 nop residual zero", wb_word, {16'h8100, 16'd0});

    sw_write(16'h0100, 16'h0000);
    chk("R2 software clears branch bit", chan_status, 16'h8000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule